// File: doc/BRIEF.md
# Return-Address Stack Predictor

This block predicts the target of procedure returns in an instruction-fetch front end. Every cycle, decode may present one control-transfer event. The event carries a valid bit and flags for a direct jump-and-link and an indirect register jump-and-link. It also carries the destination and source register numbers and the instruction address. The block infers from the register numbers whether the event is a call, a return, a coroutine swap or none of these. It then pushes the address of the following instruction, pops a predicted return target, or does both.

The prediction appears on registered outputs one cycle after the event. The outputs are a request strobe, a valid flag that is low when the stack had nothing to give, and the predicted address. Storage is a circular buffer of `DEPTH` entries, so a call chain deeper than the buffer overwrites the oldest entries. A synchronous flush empties the stack.

The occupancy controller has three named states. EMPTY holds no entries. PARTIAL holds between one and DEPTH-1 entries. FULL holds DEPTH entries. The transitions are:

- push: EMPTY goes to PARTIAL. PARTIAL goes to FULL when the last free slot is used. FULL stays FULL and overwrites the oldest entry.
- pop: FULL goes to PARTIAL. PARTIAL goes to EMPTY when the last entry is taken. A pop in EMPTY is an underflow, and the state stays EMPTY.
- swap with at least one entry: the state is kept.
- swap in EMPTY: treated as a push, so the state goes to PARTIAL.
- flush: any state goes to EMPTY.

Top module: `ras_predictor`

## Requirements
- R1: A register number counts as a link register only when it is 1 or 5. A direct jump-and-link (`ev_is_jal`=1, which takes precedence over `ev_is_jalr`) pushes only when its destination is a link register, and it never pops.
- R2: An indirect jump whose source is a link register and whose destination is not pops the stack. One cycle later `pred_req`=1, `pred_valid`=1 and `pred_addr` holds the most recently pushed address.
- R3: An indirect jump whose destination is a link register and whose source is not pushes without predicting. An indirect jump with neither register a link register leaves the stack and the outputs idle.
- R4: An indirect jump with two different link registers pops and then pushes. The popped top is presented as the prediction, and the new return address takes the same slot, so depth is unchanged. On an empty stack this event reports an underflow and then pushes one entry.
- R5: An indirect jump whose destination and source are the same link register only pushes, and `pred_req` stays 0.
- R6: The pushed value is the event address plus 4, modulo 2^ADDR_W.
- R7: Entries are returned in last-in, first-out order.
- R8: After DEPTH+k pushes, exactly DEPTH pops return valid predictions: the newest DEPTH addresses, newest first. The next pop underflows.
- R9: A pop on an empty stack gives `pred_req`=1, `pred_valid`=0 and `pred_addr`=0, and the stack stays empty. Whenever `pred_valid` is 0, `pred_addr` is 0.
- R10: `flush` empties the stack at the next clock edge. It takes priority over an event in the same cycle, and it drives all prediction outputs to 0 for the following cycle.
- R11: The prediction outputs change only at the clock edge that follows the event. `pred_req` is 1 exactly in the cycles that follow a pop or swap event. An event with `ev_valid`=0 has no effect.
- R12: After reset the stack is empty and `pred_req`, `pred_valid` and `pred_addr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Synchronous stack clear |
| ev_valid | input | 1 | Event present this cycle |
| ev_is_jal | input | 1 | Event is a direct jump-and-link |
| ev_is_jalr | input | 1 | Event is an indirect register jump-and-link |
| ev_rd | input | 5 | Destination register number |
| ev_rs1 | input | 5 | Source register number |
| ev_pc | input | ADDR_W | Address of the event instruction |
| pred_req | output | 1 | A pop was requested on the previous cycle |
| pred_valid | output | 1 | The prediction is backed by a stack entry |
| pred_addr | output | ADDR_W | Predicted return address, 0 when not valid |

## Verification
Internal state is visible at the ports only through later pops. A slipped pointer, a wrong count or a wrong state surfaces on a later return, as a wrong `pred_addr` or as a `pred_valid` that is missing or unexpected. It can stay hidden for many events. The bench therefore drains the stack after each scenario, and in the overflow case it pops one past the expected depth. That turns latent pointer or occupancy errors into a mismatch within DEPTH+1 cycles. The flush and swap cases are each followed by pops, so the slot contents and the count are exposed.

// File: rtl/ras_pkg.sv
package ras_pkg;

    // Stack action decided from one control-transfer event
    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_PUSH = 2'd1,
        OP_POP  = 2'd2,
        OP_SWAP = 2'd3
    } ras_op_e;

    // Occupancy of the circular buffer
    typedef enum logic [1:0] {
        OCC_EMPTY   = 2'd0,
        OCC_PARTIAL = 2'd1,
        OCC_FULL    = 2'd2
    } occ_state_e;

    localparam int REG_W = 5;

endpackage

// File: rtl/ras_classify.sv
module ras_classify
    import ras_pkg::*;
#(
    parameter int LINK_A = 1,
    parameter int LINK_B = 5
) (
    input  logic             ev_valid,
    input  logic             ev_is_jal,
    input  logic             ev_is_jalr,
    input  logic [REG_W-1:0] ev_rd,
    input  logic [REG_W-1:0] ev_rs1,
    output ras_op_e          op
);

    logic dst_link;
    logic src_link;
    logic same_reg;

    assign dst_link = (ev_rd  == REG_W'(LINK_A)) || (ev_rd  == REG_W'(LINK_B));
    assign src_link = (ev_rs1 == REG_W'(LINK_A)) || (ev_rs1 == REG_W'(LINK_B));
    assign same_reg = (ev_rd == ev_rs1);

    always_comb begin
        op = OP_NONE;
        if (ev_valid) begin
            if (ev_is_jal) begin
                op = dst_link ? OP_PUSH : OP_NONE;
            end else if (ev_is_jalr) begin
                unique case ({dst_link, src_link})
                    2'b00: op = OP_NONE;
                    2'b01: op = OP_POP;
                    2'b10: op = OP_PUSH;
                    2'b11: op = same_reg ? OP_PUSH : OP_SWAP;
                    default: op = OP_NONE;
                endcase
            end
        end
    end

endmodule

// File: rtl/ras_storage.sv
module ras_storage #(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 32,
    parameter int PTR_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [PTR_W-1:0]  wr_idx,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic [PTR_W-1:0]  rd_idx,
    output logic [ADDR_W-1:0] rd_data
);

    logic [ADDR_W-1:0] slot [DEPTH];
    logic [DEPTH-1:0]  wr_sel;

    // One-hot write decode, one select per slot
    for (genvar g = 0; g < DEPTH; g++) begin : g_sel
        assign wr_sel[g] = wr_en && (wr_idx == PTR_W'(g));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) slot[i] <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (wr_sel[i]) slot[i] <= wr_data;
            end
        end
    end

    assign rd_data = slot[rd_idx];

endmodule

// File: rtl/ras_ctrl.sv
module ras_ctrl
    import ras_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int PTR_W = 3,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  ras_op_e          op,
    output logic             wr_en,
    output logic [PTR_W-1:0] wr_idx,
    output logic [PTR_W-1:0] top_idx,
    output logic             pop_ok,
    output logic             pop_req,
    output logic [CNT_W-1:0] occ_cnt
);

    occ_state_e       state_q, state_d;
    logic [PTR_W-1:0] ptr_q, ptr_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [PTR_W-1:0] ptr_inc;
    logic             has_entry;
    logic             do_push;   // grows the stack by one slot
    logic             do_pop;    // shrinks the stack by one slot
    logic             do_swap;   // rewrites the top in place

    assign has_entry = (state_q != OCC_EMPTY);
    assign ptr_inc   = (ptr_q == PTR_W'(DEPTH - 1)) ? '0 : ptr_q + 1'b1;
    assign top_idx   = (ptr_q == '0) ? PTR_W'(DEPTH - 1) : ptr_q - 1'b1;

    assign pop_req = !flush && ((op == OP_POP) || (op == OP_SWAP));
    assign pop_ok  = pop_req && has_entry;
    assign do_swap = !flush && (op == OP_SWAP) && has_entry;
    assign do_pop  = !flush && (op == OP_POP) && has_entry;
    assign do_push = !flush && ((op == OP_PUSH) || ((op == OP_SWAP) && !has_entry));

    assign wr_en  = do_push || do_swap;
    assign wr_idx = do_swap ? top_idx : ptr_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= OCC_EMPTY;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (flush) begin
            state_d = OCC_EMPTY;
        end else begin
            unique case (state_q)
                OCC_EMPTY: begin
                    if (do_push) state_d = (DEPTH == 1) ? OCC_FULL : OCC_PARTIAL;
                end
                OCC_PARTIAL: begin
                    if (do_push && (cnt_q == CNT_W'(DEPTH - 1))) state_d = OCC_FULL;
                    else if (do_pop && (cnt_q == CNT_W'(1)))     state_d = OCC_EMPTY;
                end
                OCC_FULL: begin
                    if (do_pop) state_d = (DEPTH == 1) ? OCC_EMPTY : OCC_PARTIAL;
                end
                default: state_d = OCC_EMPTY;
            endcase
        end
    end

    // Pointer and occupancy count
    always_comb begin
        ptr_d = ptr_q;
        cnt_d = cnt_q;
        if (flush) begin
            ptr_d = '0;
            cnt_d = '0;
        end else if (do_push) begin
            ptr_d = ptr_inc;
            cnt_d = (state_q == OCC_FULL) ? cnt_q : cnt_q + 1'b1;
        end else if (do_pop) begin
            ptr_d = top_idx;
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
            cnt_q <= '0;
        end else begin
            ptr_q <= ptr_d;
            cnt_q <= cnt_d;
        end
    end

    assign occ_cnt = cnt_q;

endmodule

// File: rtl/ras_predictor.sv
module ras_predictor
    import ras_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 32,
    parameter int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    parameter int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              ev_valid,
    input  logic              ev_is_jal,
    input  logic              ev_is_jalr,
    input  logic [4:0]        ev_rd,
    input  logic [4:0]        ev_rs1,
    input  logic [ADDR_W-1:0] ev_pc,
    output logic              pred_req,
    output logic              pred_valid,
    output logic [ADDR_W-1:0] pred_addr
);

    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);

    ras_op_e           op;
    logic              wr_en;
    logic [PTR_W-1:0]  wr_idx;
    logic [PTR_W-1:0]  top_idx;
    logic              pop_ok;
    logic              pop_req;
    logic [CNT_W-1:0]  occ_cnt;
    logic [ADDR_W-1:0] top_data;
    logic [ADDR_W-1:0] ret_addr;

    assign ret_addr = ev_pc + STEP;

    ras_classify u_cls (
        .ev_valid   (ev_valid),
        .ev_is_jal  (ev_is_jal),
        .ev_is_jalr (ev_is_jalr),
        .ev_rd      (ev_rd),
        .ev_rs1     (ev_rs1),
        .op         (op)
    );

    ras_ctrl #(.DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (flush),
        .op      (op),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .top_idx (top_idx),
        .pop_ok  (pop_ok),
        .pop_req (pop_req),
        .occ_cnt (occ_cnt)
    );

    ras_storage #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (ret_addr),
        .rd_idx  (top_idx),
        .rd_data (top_data)
    );

    // Registered prediction outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pred_req   <= 1'b0;
            pred_valid <= 1'b0;
            pred_addr  <= '0;
        end else begin
            pred_req   <= pop_req;
            pred_valid <= pop_ok;
            pred_addr  <= pop_ok ? top_data : '0;
        end
    end

endmodule

// File: rtl/ras_checker.sv
module ras_checker #(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              flush,
    input logic              ev_valid,
    input logic              ev_is_jal,
    input logic              ev_is_jalr,
    input logic [4:0]        ev_rd,
    input logic [4:0]        ev_rs1,
    input logic              pred_req,
    input logic              pred_valid,
    input logic [ADDR_W-1:0] pred_addr,
    input logic [CNT_W-1:0]  occ_cnt
);

    logic dl, sl, jr;
    assign dl = (ev_rd == 5'd1) || (ev_rd == 5'd5);
    assign sl = (ev_rs1 == 5'd1) || (ev_rs1 == 5'd5);
    assign jr = ev_valid && ev_is_jalr && !ev_is_jal && !flush;

    // R1
    jal_no_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && ev_is_jal && !flush) |=> !pred_req);

    // R11
    idle_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ev_valid && !flush) |=> !pred_req);

    // R10
    flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (occ_cnt == '0 && !pred_req && !pred_valid));

    // R9
    valid_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pred_valid |-> pred_req);

    // R9
    addr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pred_valid |-> (pred_addr == '0));

    // R9
    underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (jr && sl && !dl && occ_cnt == '0) |=> (pred_req && !pred_valid && occ_cnt == '0));

    // R8
    occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        occ_cnt <= CNT_W'(DEPTH));

    // R4
    swap_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (jr && sl && dl && (ev_rd != ev_rs1) && occ_cnt != '0)
        |=> (pred_valid && occ_cnt == $past(occ_cnt)));

    // R5
    same_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (jr && sl && dl && (ev_rd == ev_rs1)) |=> !pred_req);

endmodule

bind ras_predictor ras_checker #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush),
    .ev_valid   (ev_valid),
    .ev_is_jal  (ev_is_jal),
    .ev_is_jalr (ev_is_jalr),
    .ev_rd      (ev_rd),
    .ev_rs1     (ev_rs1),
    .pred_req   (pred_req),
    .pred_valid (pred_valid),
    .pred_addr  (pred_addr),
    .occ_cnt    (occ_cnt)
);

// File: tb/tb_ras_predictor.sv
module tb_ras_predictor;

    localparam int DEPTH  = 8;
    localparam int ADDR_W = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              flush = 1'b0;
    logic              ev_valid = 1'b0;
    logic              ev_is_jal = 1'b0;
    logic              ev_is_jalr = 1'b0;
    logic [4:0]        ev_rd = '0;
    logic [4:0]        ev_rs1 = '0;
    logic [ADDR_W-1:0] ev_pc = '0;
    logic              pred_req;
    logic              pred_valid;
    logic [ADDR_W-1:0] pred_addr;

    int  n_chk = 0;
    int  n_bad = 0;
    int  cyc = 0;
    bit  done = 1'b0;

    // Scoreboard queues (parallel)
    int                due_q[$];
    bit                ereq_q[$];
    bit                eval_q[$];
    logic [ADDR_W-1:0] eaddr_q[$];
    string             tag_q[$];

    // Requirement-level model of the stack
    logic [ADDR_W-1:0] mdl[$];

    always #10 clk = ~clk;   // 50 MHz

    always @(posedge clk) cyc <= cyc + 1;

    ras_predictor #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .ev_valid(ev_valid), .ev_is_jal(ev_is_jal), .ev_is_jalr(ev_is_jalr),
        .ev_rd(ev_rd), .ev_rs1(ev_rs1), .ev_pc(ev_pc),
        .pred_req(pred_req), .pred_valid(pred_valid), .pred_addr(pred_addr)
    );

    function automatic bit is_link(input logic [4:0] r);
        return (r == 5'd1) || (r == 5'd5);
    endfunction

    task automatic check(input string tag, input bit ok, input string what,
                         input logic [ADDR_W-1:0] act, input logic [ADDR_W-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Driver: one event per call, expectation due one cycle later
    task automatic send(input bit v, input bit jal, input bit jalr,
                        input logic [4:0] rd, input logic [4:0] rs1,
                        input logic [ADDR_W-1:0] pc, input bit fl, input string tag);
        bit push, pop, swap;
        bit er, ev;
        logic [ADDR_W-1:0] ea;
        @(negedge clk);
        ev_valid = v; ev_is_jal = jal; ev_is_jalr = jalr;
        ev_rd = rd; ev_rs1 = rs1; ev_pc = pc; flush = fl;
        push = 0; pop = 0; swap = 0;
        if (v && jal) push = is_link(rd);
        else if (v && jalr) begin
            if (is_link(rd) && is_link(rs1)) begin
                if (rd == rs1) push = 1; else swap = 1;
            end else if (is_link(rd)) push = 1;
            else if (is_link(rs1)) pop = 1;
        end
        er = 0; ev = 0; ea = '0;
        if (fl) begin
            mdl.delete();
        end else if (pop) begin
            er = 1;
            if (mdl.size() > 0) begin ev = 1; ea = mdl.pop_back(); end
        end else if (swap) begin
            er = 1;
            if (mdl.size() > 0) begin
                ev = 1; ea = mdl[mdl.size()-1];
                mdl[mdl.size()-1] = pc + 32'd4;
            end else mdl.push_back(pc + 32'd4);
        end else if (push) begin
            mdl.push_back(pc + 32'd4);
            if (mdl.size() > DEPTH) void'(mdl.pop_front());
        end
        due_q.push_back(cyc + 1);
        ereq_q.push_back(er);
        eval_q.push_back(ev);
        eaddr_q.push_back(ea);
        tag_q.push_back(tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) send(0, 0, 0, 5'd0, 5'd0, '0, 0, "R11");
    endtask

    // Monitor: compares results against due expectations
    always @(negedge clk) begin
        while (due_q.size() > 0 && due_q[0] == cyc) begin
            int    d;
            bit    er, ev;
            logic [ADDR_W-1:0] ea;
            string t;
            d  = due_q.pop_front();
            er = ereq_q.pop_front();
            ev = eval_q.pop_front();
            ea = eaddr_q.pop_front();
            t  = tag_q.pop_front();
            check(t, pred_req === er, "pred_req", {31'd0, pred_req}, {31'd0, er});
            check(t, pred_valid === ev, "pred_valid", {31'd0, pred_valid}, {31'd0, ev});
            check(t, pred_addr === ea, "pred_addr", pred_addr, ea);
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12: reset state
        check("R12", pred_req === 1'b0, "pred_req in reset", {31'd0, pred_req}, '0);
        check("R12", pred_valid === 1'b0, "pred_valid in reset", {31'd0, pred_valid}, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R12", pred_addr === '0, "pred_addr after reset", pred_addr, '0);

        // R1 call pushes, R1 jal with non-link rd ignored, R2/R7 returns LIFO
        send(1, 1, 0, 5'd1, 5'd0, 32'h1000, 0, "R1");
        send(1, 1, 0, 5'd0, 5'd1, 32'h1800, 0, "R1");
        send(1, 1, 1, 5'd5, 5'd1, 32'h2000, 0, "R1");
        send(1, 0, 1, 5'd0, 5'd1, 32'h9000, 0, "R7");
        send(1, 0, 1, 5'd3, 5'd5, 32'h9004, 0, "R2");
        // R9 underflow
        send(1, 0, 1, 5'd0, 5'd1, 32'h9008, 0, "R9");
        send(1, 0, 1, 5'd0, 5'd5, 32'h900c, 0, "R9");

        // R3 push-only and no-op
        send(1, 0, 1, 5'd5, 5'd0, 32'h3000, 0, "R3");
        send(1, 0, 1, 5'd0, 5'd7, 32'h3100, 0, "R3");
        // R4 swap keeps depth
        send(1, 0, 1, 5'd1, 5'd5, 32'h4000, 0, "R4");
        send(1, 0, 1, 5'd0, 5'd1, 32'h4100, 0, "R4");
        send(1, 0, 1, 5'd0, 5'd1, 32'h4200, 0, "R4");
        // R4 swap on empty then pop
        send(1, 0, 1, 5'd5, 5'd1, 32'h4300, 0, "R4");
        send(1, 0, 1, 5'd0, 5'd5, 32'h4400, 0, "R4");

        // R5 same link register
        send(1, 0, 1, 5'd1, 5'd1, 32'h5000, 0, "R5");
        send(1, 0, 1, 5'd5, 5'd5, 32'h5100, 0, "R5");
        send(1, 0, 1, 5'd0, 5'd1, 32'h5200, 0, "R5");
        send(1, 0, 1, 5'd0, 5'd1, 32'h5300, 0, "R5");

        // R6 address wrap
        send(1, 1, 0, 5'd1, 5'd0, 32'hFFFF_FFFC, 0, "R6");
        send(1, 0, 1, 5'd0, 5'd1, 32'h0, 0, "R6");

        // R8 overflow: DEPTH+2 pushes then DEPTH+1 pops
        for (int i = 0; i < DEPTH + 2; i++)
            send(1, 1, 0, 5'd1, 5'd0, 32'h6000 + 32'(i * 16), 0, "R8");
        for (int i = 0; i < DEPTH + 1; i++)
            send(1, 0, 1, 5'd0, 5'd1, 32'h7000, 0, "R8");

        // R10 flush clears and wins over same-cycle events
        send(1, 1, 0, 5'd1, 5'd0, 32'h8000, 0, "R10");
        send(1, 1, 0, 5'd5, 5'd0, 32'h8100, 0, "R10");
        send(1, 1, 0, 5'd1, 5'd0, 32'h8200, 1, "R10");
        send(1, 0, 1, 5'd0, 5'd1, 32'h8300, 1, "R10");
        send(1, 0, 1, 5'd0, 5'd1, 32'h8400, 0, "R10");

        // R11 invalid events have no effect
        send(1, 1, 0, 5'd1, 5'd0, 32'hA000, 0, "R11");
        send(0, 1, 0, 5'd1, 5'd0, 32'hB000, 0, "R11");
        send(0, 0, 1, 5'd0, 5'd1, 32'hB100, 0, "R11");
        send(1, 0, 1, 5'd0, 5'd1, 32'hB200, 0, "R11");
        send(1, 0, 1, 5'd0, 5'd1, 32'hB300, 0, "R11");
        idle(3);

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule